// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Protection

This block is the digital core of a serial memory slave on a two-wire bus with one clock line and one open-drain data line. It holds a byte array of 4096 entries by default, reached through a 12-bit word address. The block runs on a fast system clock that oversamples both bus lines. Each line goes through a synchronizer and a majority-vote glitch filter. After that the block finds START and STOP conditions and clock edges. A serial state machine uses these events to decode the control byte, the address bytes and the data bytes.

Three strap inputs set the device address, so up to eight such slaves can share one bus. A write-protect input blocks every change to the array while reads keep working. After a write that ends with a STOP, a short busy interval stands in for the internal programming time. During that interval the slave does not acknowledge its address, so a master can poll it. Any kind of termination sends the slave back to an idle standby state: a STOP, a missing acknowledge, or a control byte that does not match. In standby the slave waits for the next START.

Top module: `eeprom_i2c_slave_wp`

## Requirements
- R1: The control byte holds the device-type code (parameter, default 4'b1010) in bits 7..4, the strap value in bits 3..1, and the direction in bit 0 (1 = read). When it matches and the slave is not busy, the slave acknowledges by holding SDA low during the ninth clock. On any mismatch the slave never pulls SDA low until the next START.
- R2: The slave changes its SDA drive only while SCL is low.
- R3: A START (SDA falls while SCL is high) aborts the current transfer in any state and restarts control-byte reception. A transfer cut short this way leaves the address pointer unchanged.
- R4: A write carries two address bytes, high byte first. The upper 4 bits of the high byte are ignored, and the remaining 12 bits form the word address.
- R5: Data bytes of one write go to consecutive addresses. The low 5 address bits wrap within a 32-byte page, and the upper bits stay fixed.
- R6: While write-protect is high, data bytes are still acknowledged but no array byte changes, and no busy interval follows. Reads work unchanged.
- R7: A read returns the byte at the address pointer and then increments the pointer across the whole range. The pointer wraps from 0xFFF to 0x000.
- R8: A read that sends no address bytes starts at the pointer left by the previous access, which is the last address touched plus one.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and goes to standby. Later bytes are not acknowledged until a START.
- R10: After a STOP that ends a write in which at least one byte was stored, the slave does not acknowledge its control byte for BUSY_CYCLES system clocks. After that it acknowledges again.
- R11: A pulse one system clock long on SCL or SDA has no effect on the transfer.
- R12: After reset the slave releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Device address straps |
| wp_i | input | 1 | 1 blocks all array writes |

## Verification
The bench keeps the full 12-bit address, the 5-bit page, two synchronizer stages and a three-tap filter. With these values the wrap from 0xFFF to 0x000 and a page boundary inside the array can both be reached directly. BUSY_CYCLES is cut to 600. That is longer than one START plus control byte (about 400 system clocks at the bench's bus rate), so a poll issued right after STOP falls inside the busy window. The window also expires soon enough that many write-then-read sequences fit in the run.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  typedef struct packed {
    logic scl;
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;

endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int HALF = TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        tap_q;
  logic                   vote;

  function automatic logic majority(input logic [TAPS-1:0] t);
    majority = ($countones(t) > HALF);
  endfunction

  assign vote = majority(tap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      tap_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      tap_q  <= {tap_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= vote;
    end
  end

endmodule

// File: rtl/eep_cond_detect.sv
module eep_cond_detect
  import eep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl,
  input  logic     sda,
  output bus_evt_t evt,
  output logic     sda_o
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_comb begin
    evt.scl   = scl;
    evt.rise  = scl & ~scl_d;
    evt.fall  = ~scl & scl_d;
    evt.start = scl & scl_d & sda_d & ~sda;
    evt.stop  = scl & scl_d & ~sda_d & sda;
  end

  assign sda_o = sda;

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/eep_slave_fsm.sv
module eep_slave_fsm
  import eep_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         PAGE_W      = 5,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         BUSY_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic              sda_s,
  input  logic [2:0]        strap,
  input  logic              wp,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              sda_oe,
  output logic              busy_o
);

  localparam int HI_W   = ADDR_W - 8;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [PAGE_W-1:0] ONE_P = 1;
  localparam logic [BUSY_W-1:0] ONE_B = 1;
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES);

  eep_state_e        state, nxt;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic              in_ack;
  logic              mack;
  logic              wrote;
  logic [HI_W-1:0]   ahi;
  logic [ADDR_W-1:0] ptr;
  logic [BUSY_W-1:0] busy_cnt;

  logic byte_done;
  logic dev_byte_done;
  logic dev_match;
  logic ack_end;

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    page_next = {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + ONE_P};
  endfunction

  function automatic logic [ADDR_W-1:0] full_next(input logic [ADDR_W-1:0] a);
    full_next = a + ONE_A;
  endfunction

  assign busy_o        = (busy_cnt != '0);
  assign byte_done     = evt.fall && (bitcnt == 4'd8) && !in_ack;
  assign ack_end       = evt.fall && (bitcnt == 4'd8) && in_ack;
  assign dev_byte_done = (state == ST_DEV) && byte_done;
  assign dev_match     = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap) && !busy_o;
  assign mem_we        = (state == ST_WDATA) && byte_done && !wp;
  assign mem_wdata     = shreg;
  assign ptr_o         = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt      <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      in_ack   <= 1'b0;
      mack     <= 1'b0;
      wrote    <= 1'b0;
      ahi      <= '0;
      ptr      <= '0;
      busy_cnt <= '0;
      sda_oe   <= 1'b0;
    end else begin
      if (busy_o) busy_cnt <= busy_cnt - ONE_B;

      if (evt.start) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (evt.stop) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        if (wrote) begin
          busy_cnt <= BUSY_LOAD;
          wrote    <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_IDLE: ;

          ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
            if (evt.rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              unique case (state)
                ST_DEV: begin
                  if (dev_match) begin
                    in_ack <= 1'b1;
                    sda_oe <= 1'b1;
                    nxt    <= shreg[0] ? ST_RDATA : ST_AHI;
                  end else begin
                    state  <= ST_IDLE;
                    bitcnt <= '0;
                  end
                end
                ST_AHI: begin
                  ahi    <= shreg[HI_W-1:0];
                  in_ack <= 1'b1;
                  sda_oe <= 1'b1;
                  nxt    <= ST_ALO;
                end
                ST_ALO: begin
                  ptr    <= {ahi, shreg};
                  in_ack <= 1'b1;
                  sda_oe <= 1'b1;
                  nxt    <= ST_WDATA;
                end
                default: begin
                  ptr    <= page_next(ptr);
                  in_ack <= 1'b1;
                  sda_oe <= 1'b1;
                  nxt    <= ST_WDATA;
                  if (!wp) wrote <= 1'b1;
                end
              endcase
            end else if (ack_end) begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              state  <= nxt;
              if (nxt == ST_RDATA) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end

          ST_RDATA: begin
            if (evt.rise) begin
              if (bitcnt < 4'd8) begin
                bitcnt <= bitcnt + 4'd1;
              end else if (bitcnt == 4'd8) begin
                mack   <= ~sda_s;
                bitcnt <= 4'd9;
              end
            end else if (evt.fall) begin
              if (bitcnt >= 4'd1 && bitcnt < 4'd8) begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end else if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= full_next(ptr);
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (mack) begin
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[7];
                end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_IDLE;
                end
              end
            end
          end

          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: standby never drives the line
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R2: drive changes only with SCL low
  a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !evt.scl);

  // R3: START restarts control-byte reception
  a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> (state == ST_DEV) && (bitcnt == 4'd0) && !sda_oe);

  // R5: a stored byte never moves the pointer out of its page
  a_r5_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R10: no acknowledge of the control byte while busy
  a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_byte_done && busy_o) |=> !sda_oe);

endmodule

// File: rtl/eeprom_i2c_slave_wp.sv
module eeprom_i2c_slave_wp
  import eep_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         PAGE_W      = 5,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         BUSY_CYCLES = 1000,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILTER_TAPS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_clean;
  bus_evt_t           evt;
  logic               sda_s;
  logic [ADDR_W-1:0]  ptr;
  logic               mem_we;
  logic [7:0]         mem_wdata;
  logic [7:0]         rd_data;
  logic               busy;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_flt
    eep_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAPS       (FILTER_TAPS)
    ) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(line_raw[g]),
      .line_o(line_clean[g])
    );
  end

  eep_cond_detect u_cond (
    .clk  (clk),
    .rst_n(rst_n),
    .scl  (line_clean[0]),
    .sda  (line_clean[1]),
    .evt  (evt),
    .sda_o(sda_s)
  );

  eep_slave_fsm #(
    .ADDR_W     (ADDR_W),
    .PAGE_W     (PAGE_W),
    .DEV_TYPE   (DEV_TYPE),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .sda_s    (sda_s),
    .strap    (strap_i),
    .wp       (wp_i),
    .rd_data  (rd_data),
    .ptr_o    (ptr),
    .mem_we   (mem_we),
    .mem_wdata(mem_wdata),
    .sda_oe   (sda_oe_o),
    .busy_o   (busy)
  );

  eep_mem #(
    .ADDR_W(ADDR_W),
    .DATA_W(8)
  ) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(ptr),
    .wdata(mem_wdata),
    .raddr(ptr),
    .rdata(rd_data)
  );

  // R6: protected array sees no write strobe
  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_i);

  // R10: a write strobe never lands inside the busy window
  a_r10_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !busy);

endmodule

// File: tb/test_eeprom_i2c_slave_wp.sv
module test_eeprom_i2c_slave_wp;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int BUSY       = 600;
  localparam int WATCHDOG   = 190000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  int n_chk = 0;
  int n_bad = 0;
  int r2_viol = 0;
  logic oe_seen = 1'b0;
  logic prev_oe = 1'b0;

  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  eeprom_i2c_slave_wp #(
    .BUSY_CYCLES(BUSY)
  ) i_eeprom_i2c_slave_wp (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe),
    .strap_i (STRAP),
    .wp_i    (wp)
  );

  // R2 monitor: slave drive must not change while SCL is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) r2_viol++;
    if (sda_oe === 1'b1) oe_seen = 1'b1;
    prev_oe = sda_oe;
  end

  function automatic logic [7:0] ctl(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte_g(input logic [7:0] b, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch) begin
        tick(4); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q-5);
      end else begin
        tick(Q);
      end
      scl_m = 1'b1;
      if (glitch && b[i]) begin
        tick(5); sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(2*Q-6);
      end else begin
        tick(2*Q);
      end
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_byte_g(b, 1'b0, ack);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic mem_write(input logic [11:0] a, input int n, output logic ok);
    logic ack;
    ok = 1'b1;
    bus_start();
    send_byte(ctl(1'b0), ack); ok &= ack;
    send_byte({4'hF, a[11:8]}, ack); ok &= ack;
    send_byte(a[7:0], ack); ok &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); ok &= ack;
    end
    bus_stop();
  endtask

  task automatic mem_read_rand(input logic [11:0] a, input int n, output logic ok);
    logic ack;
    ok = 1'b1;
    bus_start();
    send_byte(ctl(1'b0), ack); ok &= ack;
    send_byte({4'h0, a[11:8]}, ack); ok &= ack;
    send_byte(a[7:0], ack); ok &= ack;
    bus_start();
    send_byte(ctl(1'b1), ack); ok &= ack;
    for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
    bus_stop();
  endtask

  task automatic mem_read_cur(input int n, output logic ok);
    logic ack;
    bus_start();
    send_byte(ctl(1'b1), ack); ok = ack;
    for (int i = 0; i < n; i++) recv_byte(i != n-1, rbuf[i]);
    bus_stop();
  endtask

  task automatic poll(output logic ack);
    bus_start();
    send_byte(ctl(1'b0), ack);
    bus_stop();
  endtask

  task automatic wait_busy();
    tick(BUSY + 100);
  endtask

  task automatic t_reset();
    chk("R12 sda released", 32'(sda_oe), 32'h0);
    chk("R12 line high", 32'(sda_line), 32'h1);
  endtask

  task automatic t_byte_write();
    logic ok;
    wbuf[0] = 8'h3C;
    mem_write(12'h123, 1, ok);
    chk("R1 write acks", 32'(ok), 32'h1);
    wait_busy();
    mem_read_rand(12'h123, 1, ok);
    chk("R1 read acks", 32'(ok), 32'h1);
    chk("R4 high nibble ignored", 32'(rbuf[0]), 32'h3C);
  endtask

  task automatic t_mismatch();
    logic ack;
    oe_seen = 1'b0;
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ack);
    chk("R1 strap mismatch nack", 32'(ack), 32'h0);
    send_byte(8'h00, ack);
    chk("R1 following byte nack", 32'(ack), 32'h0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, ack);
    chk("R1 type mismatch nack", 32'(ack), 32'h0);
    bus_stop();
    chk("R1 line never pulled", 32'(oe_seen), 32'h0);
  endtask

  task automatic t_busy();
    logic ok, ack;
    wbuf[0] = 8'h42;
    mem_write(12'h050, 1, ok);
    poll(ack);
    chk("R10 poll during busy nack", 32'(ack), 32'h0);
    wait_busy();
    poll(ack);
    chk("R10 poll after busy ack", 32'(ack), 32'h1);
    mem_read_rand(12'h050, 1, ok);
    chk("R10 data stored", 32'(rbuf[0]), 32'h42);
  endtask

  task automatic t_page();
    logic ok;
    wbuf[0] = 8'h99;
    mem_write(12'h060, 1, ok);
    wait_busy();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    mem_write(12'h05E, 4, ok);
    chk("R5 page write acks", 32'(ok), 32'h1);
    wait_busy();
    mem_read_rand(12'h05E, 3, ok);
    chk("R5 byte at 05E", 32'(rbuf[0]), 32'h11);
    chk("R5 byte at 05F", 32'(rbuf[1]), 32'h22);
    chk("R5 next page untouched", 32'(rbuf[2]), 32'h99);
    mem_read_rand(12'h040, 2, ok);
    chk("R5 wrapped to 040", 32'(rbuf[0]), 32'h33);
    chk("R5 wrapped to 041", 32'(rbuf[1]), 32'h44);
  endtask

  task automatic t_wp();
    logic ok, ack;
    wbuf[0] = 8'h5A;
    mem_write(12'h100, 1, ok);
    wait_busy();
    wp = 1'b1;
    wbuf[0] = 8'hA5;
    mem_write(12'h100, 1, ok);
    chk("R6 protected write acked", 32'(ok), 32'h1);
    poll(ack);
    chk("R6 no busy after protected write", 32'(ack), 32'h1);
    mem_read_rand(12'h100, 1, ok);
    chk("R6 read under protect", 32'(rbuf[0]), 32'h5A);
    wp = 1'b0;
  endtask

  task automatic t_seq_wrap();
    logic ok;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
    mem_write(12'hFFE, 2, ok);
    wait_busy();
    wbuf[0] = 8'hC3; wbuf[1] = 8'hD4;
    mem_write(12'h000, 2, ok);
    wait_busy();
    mem_read_rand(12'hFFE, 3, ok);
    chk("R7 read FFE", 32'(rbuf[0]), 32'hA1);
    chk("R7 read FFF", 32'(rbuf[1]), 32'hB2);
    chk("R7 wrap to 000", 32'(rbuf[2]), 32'hC3);
    mem_read_cur(1, ok);
    chk("R8 current read ack", 32'(ok), 32'h1);
    chk("R8 current read 001", 32'(rbuf[0]), 32'hD4);
  endtask

  task automatic t_nack();
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(ctl(1'b0), ack);
    send_byte(8'h01, ack);
    send_byte(8'h23, ack);
    bus_start();
    send_byte(ctl(1'b1), ack);
    recv_byte(1'b0, b);
    chk("R9 byte before nack", 32'(b), 32'h3C);
    send_byte(ctl(1'b0), ack);
    chk("R9 standby ignores byte", 32'(ack), 32'h0);
    bus_stop();
  endtask

  task automatic t_abort();
    logic ok, ack;
    logic [7:0] b;
    wbuf[0] = 8'h77;
    mem_write(12'h234, 1, ok);
    wait_busy();
    wbuf[0] = 8'h66;
    mem_write(12'h235, 1, ok);
    wait_busy();
    mem_read_rand(12'h234, 1, ok);
    chk("R3 setup read", 32'(rbuf[0]), 32'h77);
    bus_start();
    send_byte(ctl(1'b0), ack);
    send_byte(8'h0F, ack);
    bus_start();
    send_byte(ctl(1'b1), ack);
    chk("R3 restart acked", 32'(ack), 32'h1);
    recv_byte(1'b0, b);
    bus_stop();
    chk("R3 pointer kept after abort", 32'(b), 32'h66);
  endtask

  task automatic t_glitch();
    logic ok, ack;
    bus_start();
    send_byte(ctl(1'b0), ack);
    send_byte(8'h03, ack);
    send_byte(8'h00, ack);
    send_byte_g(8'hB5, 1'b1, ack);
    chk("R11 glitched byte acked", 32'(ack), 32'h1);
    bus_stop();
    wait_busy();
    mem_read_rand(12'h300, 1, ok);
    chk("R11 glitched byte stored", 32'(rbuf[0]), 32'hB5);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(10);
    t_byte_write();
    t_mismatch();
    t_busy();
    t_page();
    t_wp();
    t_seq_wrap();
    t_nack();
    t_abort();
    t_glitch();
    chk("R2 drive changes with SCL high", 32'(r2_viol), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule